// File: doc/BRIEF.md
# Stride Address and Store-Conflict Predictor

This block lets a load reach the data cache before the addresses of older stores are known. A direct-mapped table, indexed by the low bits of the instruction PC, learns each memory instruction's address stream as a last address plus a stride. At dispatch it returns a predicted effective address and a flag that says whether that prediction may be trusted. When the real address resolves, the train port updates the entry. If a trusted prediction was wrong, the block raises a flush of all younger instructions.

A second table keeps one sticky bit per index. The bit is set when a store at that PC forwards data to a load inside the load/store queue. The early-issue query takes a load PC and the PCs of the older unresolved stores. It answers permit when the load's own prediction is trusted and none of those stores can plausibly alias with it. A store that has never forwarded does not count. A store whose address prediction is trusted is checked through that predicted address.

Top module: `stride_conflict_pred`

## Requirements
- R1: After reset every lookup reports no confidence, `flush_o` is low and `q_permit` is low.
- R2: A train whose PC tag misses its entry allocates it: the last address becomes the trained address, the stride becomes 0 and confidence becomes 0, so a lookup returns the trained address without confidence.
- R3: The lookup address is last address plus stride. The confidence flag rises once the stride has matched on five consecutive trains (a 3-bit saturating counter reaches 5).
- R4: A train whose computed stride (actual minus last) differs from the stored one, on an entry that is not yet trusted, stores the new stride and sets confidence to 0.
- R5: A train on a trusted entry whose actual address differs from last plus stride raises `flush_o` for exactly the cycle after the train. The stride is kept and the last address takes the actual value.
- R6: Five wrong trusted predictions with no correct one in between clear the entry's stride and confidence. A correct prediction resets the wrong-prediction count to 0.
- R7: A store-forward event sets the conflict bit for that store PC's index. Valid older stores whose bit is clear do not block the permit.
- R8: `q_permit` is 1 only if the load prediction is trusted and every valid store slot either has a clear conflict bit or has a trusted prediction whose word address (bits above 1) differs from the load's. Invalid slots are ignored.
- R9: A lookup in the same cycle as a train to the same index returns the contents from before the train. The update is visible from the next cycle.
- R10: A train with a different tag at an occupied index replaces the entry, so the old PC loses its confidence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | AW | Dispatch lookup PC |
| lk_addr | output | AW | Predicted address for `lk_pc` |
| lk_conf | output | 1 | Prediction is trusted |
| tr_valid | input | 1 | Train strobe |
| tr_pc | input | AW | PC of the resolved instruction |
| tr_addr | input | AW | Actual effective address |
| fwd_valid | input | 1 | A store forwarded data to a load |
| fwd_pc | input | AW | PC of the forwarding store |
| q_ld_pc | input | AW | Early-issue query: load PC |
| q_st_valid | input | NST | Older unresolved store slot valid |
| q_st_pc | input | NST*AW | Store slot PCs, slot i at bits i*AW |
| q_permit | output | 1 | Load may access the cache early |
| flush_o | output | 1 | Trusted prediction was wrong; flush younger instructions |

## Verification
Lookup and permit results are combinational from the table state, so they are sampled a short delay after the inputs settle. A train or forward event takes effect at the next rising edge. `flush_o` is registered and is due in the cycle right after the train edge. The bench drives inputs on falling edges and samples on the next falling edge, one register stage later. The same-cycle check samples before that edge to catch the old contents.

// File: rtl/stride_conflict_pred.sv
module stride_conflict_pred #(
  parameter int AW    = 32,
  parameter int IDX_W = 4,
  parameter int TAG_W = 6,
  parameter int NST   = 2,
  parameter int TRUST = 5,
  parameter int DECAY = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   lk_pc,
  output logic [AW-1:0]   lk_addr,
  output logic            lk_conf,
  input  logic            tr_valid,
  input  logic [AW-1:0]   tr_pc,
  input  logic [AW-1:0]   tr_addr,
  input  logic            fwd_valid,
  input  logic [AW-1:0]   fwd_pc,
  input  logic [AW-1:0]   q_ld_pc,
  input  logic [NST-1:0]  q_st_valid,
  input  logic [NST*AW-1:0] q_st_pc,
  output logic            q_permit,
  output logic            flush_o
);
  localparam int N   = 1 << IDX_W;
  localparam int TLO = IDX_W + 2;
  localparam int NR  = NST + 2;

  logic [AW-1:0]    last_q   [N];
  logic [AW-1:0]    stride_q [N];
  logic [TAG_W-1:0] tag_q    [N];
  logic [2:0]       conf_q   [N];
  logic [2:0]       miss_q   [N];
  logic [N-1:0]     vld_q;
  logic [N-1:0]     cbit_q;
  logic             flush_q;

  logic [NR-1:0][AW-1:0] rd_pc;
  logic [IDX_W-1:0] rd_idx  [NR];
  logic             rd_hit  [NR];
  logic             rd_conf [NR];
  logic [AW-1:0]    rd_pred [NR];

  assign rd_pc[0] = lk_pc;
  assign rd_pc[1] = q_ld_pc;

  for (genvar s = 0; s < NST; s++) begin : g_st
    assign rd_pc[2+s] = q_st_pc[s*AW +: AW];
  end

  for (genvar r = 0; r < NR; r++) begin : g_rd
    assign rd_idx[r]  = rd_pc[r][TLO-1:2];
    assign rd_hit[r]  = vld_q[rd_idx[r]] && (tag_q[rd_idx[r]] == rd_pc[r][TLO+TAG_W-1:TLO]);
    assign rd_conf[r] = rd_hit[r] && (conf_q[rd_idx[r]] >= 3'(TRUST));
    assign rd_pred[r] = last_q[rd_idx[r]] + stride_q[rd_idx[r]];
  end

  assign lk_addr = rd_pred[0];
  assign lk_conf = rd_conf[0];

  logic ld_conf;
  assign ld_conf = rd_conf[1];

  always_comb begin
    q_permit = ld_conf;
    for (int s = 0; s < NST; s++) begin
      if (q_st_valid[s] && cbit_q[rd_idx[2+s]] &&
          !(rd_conf[2+s] && ((rd_pred[2+s] >> 2) != (rd_pred[1] >> 2))))
        q_permit = 1'b0;
    end
  end

  logic [IDX_W-1:0] ti, fi;
  logic             thit, ttrust, tmatch, twrong;
  logic [AW-1:0]    tstride;

  assign ti      = tr_pc[TLO-1:2];
  assign fi      = fwd_pc[TLO-1:2];
  assign thit    = vld_q[ti] && (tag_q[ti] == tr_pc[TLO+TAG_W-1:TLO]);
  assign ttrust  = thit && (conf_q[ti] >= 3'(TRUST));
  assign tstride = tr_addr - last_q[ti];
  assign tmatch  = (tstride == stride_q[ti]);
  assign twrong  = tr_valid && ttrust && !tmatch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      cbit_q  <= '0;
      flush_q <= 1'b0;
      for (int e = 0; e < N; e++) begin
        last_q[e]   <= '0;
        stride_q[e] <= '0;
        tag_q[e]    <= '0;
        conf_q[e]   <= '0;
        miss_q[e]   <= '0;
      end
    end else begin
      flush_q <= twrong;
      if (fwd_valid) cbit_q[fi] <= 1'b1;
      if (tr_valid) begin
        last_q[ti] <= tr_addr;
        if (!thit) begin
          vld_q[ti]    <= 1'b1;
          tag_q[ti]    <= tr_pc[TLO+TAG_W-1:TLO];
          stride_q[ti] <= '0;
          conf_q[ti]   <= '0;
          miss_q[ti]   <= '0;
        end else if (tmatch) begin
          if (conf_q[ti] != 3'd7) conf_q[ti] <= conf_q[ti] + 3'd1;
          miss_q[ti] <= '0;
        end else if (ttrust) begin
          if (miss_q[ti] == 3'(DECAY-1)) begin
            stride_q[ti] <= '0;
            conf_q[ti]   <= '0;
            miss_q[ti]   <= '0;
          end else begin
            miss_q[ti] <= miss_q[ti] + 3'd1;
          end
        end else begin
          stride_q[ti] <= tstride;
          conf_q[ti]   <= '0;
          miss_q[ti]   <= '0;
        end
      end
    end
  end

  assign flush_o = flush_q;

  logic unused_bits;
  assign unused_bits = ^{rd_pc, tr_pc, fwd_pc};

  // R5
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> $past(tr_valid));

  // R8
  permit_conf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_permit |-> ld_conf);

  // R7
  cbit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fwd_valid) |-> cbit_q[$past(fi)]);

  // R2
  alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tr_valid && !thit) |-> (conf_q[$past(ti)] == 3'd0 && vld_q[$past(ti)]));

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R6
    miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      miss_q[g] < 3'(DECAY));
  end
endmodule

// File: tb/stride_conflict_pred_tb.sv
module stride_conflict_pred_tb;
  localparam int AW  = 32;
  localparam int NST = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] lk_pc = '0, tr_pc = '0, tr_addr = '0, fwd_pc = '0, q_ld_pc = '0;
  logic tr_valid = 1'b0, fwd_valid = 1'b0;
  logic [NST-1:0] q_st_valid = '0;
  logic [NST*AW-1:0] q_st_pc = '0;
  logic [AW-1:0] lk_addr;
  logic lk_conf, q_permit, flush_o;

  always #4 clk = ~clk;

  stride_conflict_pred #(.AW(AW), .NST(NST)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_addr(lk_addr), .lk_conf(lk_conf),
    .tr_valid(tr_valid), .tr_pc(tr_pc), .tr_addr(tr_addr),
    .fwd_valid(fwd_valid), .fwd_pc(fwd_pc), .q_ld_pc(q_ld_pc),
    .q_st_valid(q_st_valid), .q_st_pc(q_st_pc), .q_permit(q_permit), .flush_o(flush_o)
  );

  localparam logic [AW-1:0] PA = 32'h104, PB = 32'h208, PS1 = 32'h30C, PS2 = 32'h410, PX = 32'h248;

  // {train address, expected lookup address, expected confidence, expected flush}
  localparam logic [65:0] VEC [17] = '{
    {32'h1000, 32'h1000, 1'b0, 1'b0},
    {32'h1010, 32'h1020, 1'b0, 1'b0},
    {32'h1020, 32'h1030, 1'b0, 1'b0},
    {32'h1030, 32'h1040, 1'b0, 1'b0},
    {32'h1040, 32'h1050, 1'b0, 1'b0},
    {32'h1050, 32'h1060, 1'b0, 1'b0},
    {32'h1060, 32'h1070, 1'b1, 1'b0},
    {32'h1070, 32'h1080, 1'b1, 1'b0},
    {32'h2000, 32'h2010, 1'b1, 1'b1},
    {32'h2010, 32'h2020, 1'b1, 1'b0},
    {32'h3000, 32'h3010, 1'b1, 1'b1},
    {32'h4000, 32'h4010, 1'b1, 1'b1},
    {32'h5000, 32'h5010, 1'b1, 1'b1},
    {32'h6000, 32'h6010, 1'b1, 1'b1},
    {32'h7000, 32'h7000, 1'b0, 1'b1},
    {32'h7008, 32'h7010, 1'b0, 1'b0},
    {32'h7010, 32'h7018, 1'b0, 1'b0}
  };

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic train(input logic [AW-1:0] pc, input logic [AW-1:0] addr);
    tr_valid = 1'b1; tr_pc = pc; tr_addr = addr;
    @(negedge clk);
    tr_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lk_pc = PA; q_ld_pc = PA;
    #1;
    check("R1 conf", 32'(lk_conf), 32'd0);
    check("R1 flush", 32'(flush_o), 32'd0);
    check("R1 permit", 32'(q_permit), 32'd0);

    // R2 R3 R4 R5 R6 vector walk on PC A
    for (int k = 0; k < 17; k++) begin
      tr_valid = 1'b1; tr_pc = PA; tr_addr = VEC[k][65:34];
      @(negedge clk);
      check($sformatf("R3 vec%0d addr", k), lk_addr, VEC[k][33:2]);
      check($sformatf("R3 vec%0d conf", k), 32'(lk_conf), 32'(VEC[k][1]));
      check($sformatf("R5 R6 vec%0d flush", k), 32'(flush_o), 32'(VEC[k][0]));
    end
    tr_valid = 1'b0;

    // R9 same-cycle lookup and train
    tr_valid = 1'b1; tr_pc = PA; tr_addr = 32'h9000;
    #1;
    check("R9 old addr", lk_addr, 32'h7018);
    @(negedge clk);
    tr_valid = 1'b0;
    check("R9 new addr", lk_addr, 32'hAFF0);
    check("R4 conf", 32'(lk_conf), 32'd0);

    // load B confident, prediction 0x401C
    for (int k = 0; k < 7; k++) train(PB, 32'h4000 + 32'(4*k));
    lk_pc = PB; q_ld_pc = PB;
    q_st_pc = {PS2, PS1}; q_st_valid = 2'b11;
    #1;
    check("R3 B addr", lk_addr, 32'h401C);
    check("R3 B conf", 32'(lk_conf), 32'd1);
    check("R7 no conflict bits", 32'(q_permit), 32'd1);

    fwd_valid = 1'b1; fwd_pc = PS1;
    @(negedge clk);
    fwd_valid = 1'b0;
    #1;
    check("R8 conflicting store", 32'(q_permit), 32'd0);
    q_st_valid = 2'b10;
    #1;
    check("R8 invalid slot", 32'(q_permit), 32'd1);
    q_st_valid = 2'b11;

    for (int k = 0; k < 7; k++) train(PS1, 32'h4000 + 32'(4*k));
    lk_pc = PS1;
    #1;
    check("R3 S1 conf", 32'(lk_conf), 32'd1);
    check("R8 same word", 32'(q_permit), 32'd0);
    train(PS1, 32'h401C);
    #1;
    check("R8 different word", 32'(q_permit), 32'd1);
    q_ld_pc = PA;
    #1;
    check("R8 load not trusted", 32'(q_permit), 32'd0);
    q_ld_pc = PB;

    // R10 replacement
    train(PX, 32'h600);
    lk_pc = PB;
    #1;
    check("R10 old conf", 32'(lk_conf), 32'd0);
    check("R10 permit", 32'(q_permit), 32'd0);
    lk_pc = PX;
    #1;
    check("R10 new addr", lk_addr, 32'h600);
    check("R2 new conf", 32'(lk_conf), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule